// File: doc/BRIEF.md
# Pipeline Interlock and Bypass Controller

This block decides, each cycle, where the operands of a five-stage integer pipeline come from and when the front of the pipeline must wait. The stages are fetch, decode with register read, execute, memory and writeback. The block reads the register specifiers and control flags held in the pipeline latches. From them it produces three groups of outputs. The first is the operand-source codes for the two execute-stage inputs. The second is a store-data bypass select for the memory stage and a bypass select for the decode-stage branch operand. The third is a hold for the PC and the fetch/decode latch, with a matching bubble into the decode/execute latch. The block is purely combinational.

Branches test one register against zero in decode, and a single delay slot always executes after them. Any value a branch needs must therefore be present in decode, either by bypass or by waiting. Registers are read only in decode and written only in writeback, so read-after-write is the only hazard the block handles. The register file writes in the first half of a cycle and reads in the second, so a writeback-stage producer never needs a decode bypass. Register 0 is hard-wired to zero and never takes part in a hazard.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each execute operand select (`ex_sel_a`, `ex_sel_b`) is 1 when the memory-stage latch holds a non-load instruction writing that operand's nonzero register. Otherwise it is 2 when the writeback latch writes that register. Otherwise it is 0. The memory-stage producer wins when both match.
- R2: A specifier of register 0 never yields a nonzero select and never causes a hold.
- R3: Take a load in execute writing a nonzero register, and a decode instruction that reads that register as an execute input. Reading operand A, or being a branch, counts. So does reading operand B where B is not store-data only. This case raises `hold_front` for that cycle.
- R4: A load in execute whose register is used by the decode instruction only as store data (`id_b_is_sdata` = 1) causes no hold.
- R5: `mem_sdata_sel` is 1 exactly when the memory stage holds a store whose data register is nonzero and written by the writeback latch.
- R6: A decode branch whose test register is written by a non-load in execute raises `hold_front`, which costs one bubble.
- R7: A decode branch whose test register is written by a load raises `hold_front` while the load is in execute and again while it is in memory, which costs two bubbles.
- R8: `br_sel` is 1 when the memory-stage latch holds a non-load writing the nonzero branch test register. That case adds no hold.
- R9: A writeback-stage producer of the branch test register neither holds nor sets `br_sel`.
- R10: `idex_bubble` always equals `hold_front`. A latch whose write flag is 0 never causes a select or a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | 5 | Decode instruction first source register (branch test register) |
| id_src_b | input | 5 | Decode instruction second source register |
| id_reads_a | input | 1 | Decode instruction reads first source in execute |
| id_reads_b | input | 1 | Decode instruction reads second source |
| id_b_is_sdata | input | 1 | Second source is store data only |
| id_is_branch | input | 1 | Decode instruction is a zero-test branch |
| ex_src_a | input | 5 | Execute instruction first source |
| ex_src_b | input | 5 | Execute instruction second source |
| ex_dst | input | 5 | Execute instruction destination |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Memory-stage destination |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_src_b | input | 5 | Memory-stage store data register |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| wb_dst | input | 5 | Writeback destination |
| wb_wr | input | 1 | Writeback instruction writes a register |
| ex_sel_a | output | 2 | Execute operand A source: 0 file, 1 memory latch, 2 writeback latch |
| ex_sel_b | output | 2 | Execute operand B source, same coding |
| mem_sdata_sel | output | 1 | 1 selects writeback value as store data |
| br_sel | output | 1 | 1 selects memory-latch result for branch test |
| hold_front | output | 1 | Freeze PC and fetch/decode latch |
| idex_bubble | output | 1 | Load a no-op with write flags cleared into decode/execute |

## Verification
The execute-select sweep runs every pairing of memory and writeback producers over registers 0 to 3, with both write flags and the load flag varied. This separates the priority rule from the load exclusion and from register 0. The interlock sweep crosses decode readers (operand A, operand B, store-data only, branch) with every execute and memory producer kind. It tells a one-bubble branch wait apart from the load wait, from the memory-stage branch bypass and from the free store-data case. A store-bypass sweep pairs writeback writers with memory-stage stores.

// File: rtl/phc_pkg.sv
package phc_pkg;
    localparam int unsigned PHC_REGS = 32;
    localparam int unsigned PHC_RW   = $clog2(PHC_REGS);

    typedef enum logic [1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2
    } ex_src_e;

    typedef enum logic {
        BR_RF    = 1'b0,
        BR_EXMEM = 1'b1
    } br_src_e;

    // Youngest producer first.
    function automatic ex_src_e pick_src(input logic hit_mem, input logic hit_wb);
        if (hit_mem)     return SRC_EXMEM;
        else if (hit_wb) return SRC_MEMWB;
        else             return SRC_RF;
    endfunction
endpackage

// File: rtl/phc_ex_bypass.sv
module phc_ex_bypass
    import phc_pkg::*;
#(
    parameter int unsigned RW = PHC_RW
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic          mem_is_load,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wr,
    output ex_src_e       sel
);
    logic src_nz, hit_mem, hit_wb;

    always_comb begin
        src_nz  = (src != '0);
        // A load's data is not in the memory latch yet.
        hit_mem = src_nz && mem_wr && !mem_is_load && (mem_dst == src);
        hit_wb  = src_nz && wb_wr && (wb_dst == src);
        sel     = pick_src(hit_mem, hit_wb);

        p_zero_never_forwarded_r2: assert (src != '0 || sel == SRC_RF)
            else $error("register 0 forwarded");
        p_wb_needs_writer_r1: assert (sel != SRC_MEMWB || (wb_wr && wb_dst == src))
            else $error("writeback select without writer");
        p_mem_not_load_r1: assert (sel != SRC_EXMEM || !mem_is_load)
            else $error("load forwarded from memory latch");
    end
endmodule

// File: rtl/phc_interlock.sv
module phc_interlock
    import phc_pkg::*;
#(
    parameter int unsigned RW = PHC_RW
) (
    input  logic [RW-1:0] id_src_a,
    input  logic [RW-1:0] id_src_b,
    input  logic          id_reads_a,
    input  logic          id_reads_b,
    input  logic          id_b_is_sdata,
    input  logic          id_is_branch,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_is_load,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic          mem_is_load,
    output logic          hold
);
    logic ex_live, mem_live;
    logic need_a, need_b;
    logic load_use, br_wait_ex, br_wait_mem;

    always_comb begin
        ex_live     = ex_wr && (ex_dst != '0);
        mem_live    = mem_wr && (mem_dst != '0);
        need_a      = id_reads_a || id_is_branch;
        need_b      = id_reads_b && !id_b_is_sdata;
        load_use    = ex_live && ex_is_load &&
                      ((need_a && ex_dst == id_src_a) || (need_b && ex_dst == id_src_b));
        br_wait_ex  = id_is_branch && ex_live && !ex_is_load && (ex_dst == id_src_a);
        br_wait_mem = id_is_branch && mem_live && mem_is_load && (mem_dst == id_src_a);
        hold        = load_use || br_wait_ex || br_wait_mem;

        p_hold_needs_writer_r10: assert (!hold || (ex_wr || mem_wr))
            else $error("hold without any writer");
        p_hold_never_reg0_r2: assert (!hold || (ex_dst != '0) || (mem_dst != '0))
            else $error("hold on register 0");
        p_sdata_only_free_r4: assert (!(hold && !id_is_branch && !id_reads_a && id_b_is_sdata))
            else $error("store data caused hold");
    end
endmodule

// File: rtl/phc_dec_bypass.sv
module phc_dec_bypass
    import phc_pkg::*;
#(
    parameter int unsigned RW = PHC_RW
) (
    input  logic [RW-1:0] br_src,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic          mem_is_load,
    input  logic [RW-1:0] mem_src_b,
    input  logic          mem_is_store,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wr,
    output br_src_e       br_sel,
    output logic          sdata_sel
);
    always_comb begin
        br_sel    = (br_src != '0 && mem_wr && !mem_is_load && mem_dst == br_src)
                    ? BR_EXMEM : BR_RF;
        sdata_sel = mem_is_store && (mem_src_b != '0) && wb_wr && (wb_dst == mem_src_b);

        p_br_bypass_alu_only_r8: assert (br_sel == BR_RF || (!mem_is_load && mem_wr))
            else $error("branch bypass from load");
        p_sdata_needs_store_r5: assert (!sdata_sel || (mem_is_store && wb_wr))
            else $error("store bypass without store");
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import phc_pkg::*;
#(
    parameter int unsigned RW = PHC_RW
) (
    input  logic [RW-1:0] id_src_a,
    input  logic [RW-1:0] id_src_b,
    input  logic          id_reads_a,
    input  logic          id_reads_b,
    input  logic          id_b_is_sdata,
    input  logic          id_is_branch,
    input  logic [RW-1:0] ex_src_a,
    input  logic [RW-1:0] ex_src_b,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_is_load,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic          mem_is_load,
    input  logic [RW-1:0] mem_src_b,
    input  logic          mem_is_store,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wr,
    output logic [1:0]    ex_sel_a,
    output logic [1:0]    ex_sel_b,
    output logic          mem_sdata_sel,
    output logic          br_sel,
    output logic          hold_front,
    output logic          idex_bubble
);
    localparam int unsigned N_OPS = 2;

    logic [RW-1:0] op_src [N_OPS];
    ex_src_e       op_sel [N_OPS];
    br_src_e       br_pick;
    logic          hold;

    assign op_src[0] = ex_src_a;
    assign op_src[1] = ex_src_b;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        phc_ex_bypass #(.RW(RW)) u_byp (
            .src        (op_src[g]),
            .mem_dst    (mem_dst),
            .mem_wr     (mem_wr),
            .mem_is_load(mem_is_load),
            .wb_dst     (wb_dst),
            .wb_wr      (wb_wr),
            .sel        (op_sel[g])
        );
    end

    phc_interlock #(.RW(RW)) u_lock (
        .id_src_a     (id_src_a),
        .id_src_b     (id_src_b),
        .id_reads_a   (id_reads_a),
        .id_reads_b   (id_reads_b),
        .id_b_is_sdata(id_b_is_sdata),
        .id_is_branch (id_is_branch),
        .ex_dst       (ex_dst),
        .ex_wr        (ex_wr),
        .ex_is_load   (ex_is_load),
        .mem_dst      (mem_dst),
        .mem_wr       (mem_wr),
        .mem_is_load  (mem_is_load),
        .hold         (hold)
    );

    phc_dec_bypass #(.RW(RW)) u_dec (
        .br_src      (id_src_a),
        .mem_dst     (mem_dst),
        .mem_wr      (mem_wr),
        .mem_is_load (mem_is_load),
        .mem_src_b   (mem_src_b),
        .mem_is_store(mem_is_store),
        .wb_dst      (wb_dst),
        .wb_wr       (wb_wr),
        .br_sel      (br_pick),
        .sdata_sel   (mem_sdata_sel)
    );

    assign ex_sel_a    = op_sel[0];
    assign ex_sel_b    = op_sel[1];
    assign br_sel      = br_pick;
    assign hold_front  = hold;
    assign idex_bubble = hold;
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, mem_src_b, wb_dst;
    logic id_reads_a, id_reads_b, id_b_is_sdata, id_is_branch;
    logic ex_wr, ex_is_load, mem_wr, mem_is_load, mem_is_store, wb_wr;
    logic [1:0] ex_sel_a, ex_sel_b;
    logic mem_sdata_sel, br_sel, hold_front, idex_bubble;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pipe_hazard_ctrl uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        {id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, mem_src_b, wb_dst} = '0;
        {id_reads_a, id_reads_b, id_b_is_sdata, id_is_branch} = '0;
        {ex_wr, ex_is_load, mem_wr, mem_is_load, mem_is_store, wb_wr} = '0;
    endtask

    // R1/R2 expected source code
    function automatic int exp_src(int s, int md, bit mw, bit ml, int wd, bit ww);
        if (s != 0 && mw && !ml && md == s) return 1;
        if (s != 0 && ww && wd == s) return 2;
        return 0;
    endfunction

    initial begin
        idle();
        repeat (4) @(negedge clk);
        // quiet state
        chk("R10 quiet hold", hold_front, 0);
        chk("R1 quiet sel", ex_sel_a + ex_sel_b, 0);
        chk("R8 quiet br", br_sel, 0);
        chk("R5 quiet sdata", mem_sdata_sel, 0);

        // Execute operand sweep (R1, R2, R10)
        for (int s = 0; s < 4; s++)
          for (int md = 0; md < 4; md++)
            for (int wd = 0; wd < 4; wd++)
              for (int f = 0; f < 8; f++) begin
                  ex_src_a = 5'(s); ex_src_b = 5'((s + 1) % 4);
                  mem_dst = 5'(md); wb_dst = 5'(wd);
                  mem_wr = f[0]; mem_is_load = f[1]; wb_wr = f[2];
                  #1;
                  chk("R1 sel a", ex_sel_a, exp_src(s, md, f[0], f[1], wd, f[2]));
                  chk("R2 sel b", ex_sel_b, exp_src((s + 1) % 4, md, f[0], f[1], wd, f[2]));
                  #1;
              end
        idle();

        // Interlock and branch bypass sweep (R3, R4, R6, R7, R8, R10)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int ib = 0; ib < 16; ib++)
              for (int ed = 0; ed < 4; ed++)
                for (int eb = 0; eb < 4; eb++)
                  for (int md = 0; md < 4; md++)
                    for (int mb = 0; mb < 4; mb++) begin
                        bit lu, bex, bmem, na, nb;
                        int eh, eb_sel;
                        id_src_a = 5'(a); id_src_b = 5'(b);
                        {id_is_branch, id_b_is_sdata, id_reads_b, id_reads_a} = 4'(ib);
                        ex_dst = 5'(ed); {ex_is_load, ex_wr} = 2'(eb);
                        mem_dst = 5'(md); {mem_is_load, mem_wr} = 2'(mb);
                        na = ib[0] || ib[3];
                        nb = ib[1] && !ib[2];
                        lu   = eb[0] && eb[1] && ed != 0 && ((na && ed == a) || (nb && ed == b));
                        bex  = ib[3] && eb[0] && !eb[1] && ed != 0 && ed == a;
                        bmem = ib[3] && mb[0] && mb[1] && md != 0 && md == a;
                        eh = (lu || bex || bmem) ? 1 : 0;
                        eb_sel = (a != 0 && mb[0] && !mb[1] && md == a) ? 1 : 0;
                        #1;
                        if (eh != hold_front) begin
                            if (lu)        chk("R3 load-use hold", hold_front, eh);
                            else if (bex)  chk("R6 branch alu hold", hold_front, eh);
                            else if (bmem) chk("R7 branch load hold", hold_front, eh);
                            else           chk("R4 no hold", hold_front, eh);
                        end else checks++;
                        chk("R10 bubble equals hold", idex_bubble, hold_front);
                        chk("R8 branch bypass", br_sel, eb_sel);
                        #1;
                    end
        idle();

        // Directed: branch on load result, two bubbles (R7)
        id_is_branch = 1; id_src_a = 5'd7;
        ex_dst = 5'd7; ex_wr = 1; ex_is_load = 1; #1;
        chk("R7 first bubble", hold_front, 1); #1;
        ex_wr = 0; ex_is_load = 0; mem_dst = 5'd7; mem_wr = 1; mem_is_load = 1; #1;
        chk("R7 second bubble", hold_front, 1); #1;
        mem_wr = 0; mem_is_load = 0; wb_dst = 5'd7; wb_wr = 1; #1;
        chk("R9 writeback no hold", hold_front, 0);
        chk("R9 writeback no bypass", br_sel, 0); #1;
        // Branch on ALU result in memory stage (R8)
        wb_wr = 0; mem_wr = 1; #1;
        chk("R8 mem bypass", br_sel, 1);
        chk("R8 mem no hold", hold_front, 0); #1;
        idle();

        // Store data bypass sweep (R5)
        for (int sb = 0; sb < 4; sb++)
          for (int wd = 0; wd < 4; wd++)
            for (int f = 0; f < 4; f++) begin
                mem_src_b = 5'(sb); wb_dst = 5'(wd);
                mem_is_store = f[0]; wb_wr = f[1];
                #1;
                chk("R5 store bypass", mem_sdata_sel,
                    (f[0] && f[1] && sb != 0 && wd == sb) ? 1 : 0);
                #1;
            end
        idle();
        // Load feeding store data only (R4)
        id_reads_b = 1; id_b_is_sdata = 1; id_src_b = 5'd4;
        ex_dst = 5'd4; ex_wr = 1; ex_is_load = 1; #1;
        chk("R4 sdata no hold", hold_front, 0); #1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule